// File: doc/BRIEF.md
# Trimmed Seconds Prescaler

This block divides an oscillator-rate clock enable down to a one-per-second tick. It applies a signed digital frequency trim by adding counts to the divider or swallowing counts from it. Each trim step moves the average rate by 10 ppm, and the trim reaches up to three steps either way. The corrections follow a 3-bit trim register. The host writes that register through a one-cycle write strobe and can read it back at any time.

Time runs in correction windows of a fixed number of enabled oscillator cycles. At the start of each window the register value last written becomes the active setting. During the window the block applies as many corrections as the magnitude field says. The corrections are placed at fixed slots spread evenly through the window. A correction that lands right next to a divider rollover waits a cycle or two, so that every rollover still gives exactly one tick.

Top module: `rtc_trim_prescaler`

## Requirements
- R1: After reset the trim readback is 000, the tick output is low, and the divider and window counters start from zero, so the first window runs at the nominal rate.
- R2: Trim code bit 2 is the direction: 0 adds counts, so the clock runs fast; 1 swallows counts, so it runs slow. Bits 1:0 are the number of 10 ppm steps, from 0 to 3. Codes 000 and 100 both mean no correction.
- R3: In each window of WIN_P enabled cycles the divider moves forward by exactly WIN_P + steps counts when adding and WIN_P - steps counts when swallowing, so the total number of ticks after n windows is floor(total counts / DIV_P).
- R4: A swallow correction holds the divider count for one enabled cycle. An add correction advances it by two in one enabled cycle.
- R5: No correction is applied while the divider count is DIV_P-2 or DIV_P-1. A correction due in that span is applied on a later enabled cycle of the same window.
- R6: The divider counts 0 to DIV_P-1. Every wrap from DIV_P-1 to 0 raises the tick for exactly one cycle, in the cycle after the wrapping edge, and the tick is never high in two consecutive cycles.
- R7: A trim write shows on the readback in the next cycle. It becomes the active setting only at the next window boundary, and the window in progress finishes with the old setting.
- R8: While the oscillator enable is low, neither the divider nor the window counter advances and no tick is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| osc_en_i | input | 1 | Oscillator-rate count enable |
| trim_we_i | input | 1 | Trim register write strobe |
| trim_wdata_i | input | 3 | Trim code to write |
| sec_tick_o | output | 1 | One-cycle seconds tick |
| trim_o | output | 3 | Trim register readback |

## Verification
The bench uses a small divider (16) and an odd window (47 enabled cycles). It runs all eight trim codes one after another, with writes issued in the middle of a window and with the enable gated in some phases. At every window boundary it compares the tick count so far with the floor of the cumulative expected counts. This catches a design with the direction reversed, the wrong number of corrections, corrections lost or doubled when they collide with a rollover, or a write that takes effect at once instead of at the boundary. The window is one count short of a tick multiple, so a single stray add in the first window shows up as an extra tick. Separate checks watch for double ticks, for ticks while the enable is low, and for reset restoring the nominal rate.

// File: rtl/rtc_trim_pkg.sv
package rtc_trim_pkg;

  typedef struct packed {
    logic       slow;   // 1: swallow counts, 0: add counts
    logic [1:0] steps;  // corrections per window
  } trim_t;

  localparam int unsigned TRIM_W    = $bits(trim_t);
  localparam int unsigned MAX_STEPS = 3;

  typedef enum logic [1:0] {
    CORR_NONE = 2'd0,
    CORR_ADD  = 2'd1,
    CORR_SKIP = 2'd2
  } corr_e;

endpackage

// File: rtl/rtc_trim_reg.sv
module rtc_trim_reg
  import rtc_trim_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  we_i,
  input  trim_t wdata_i,
  input  logic  load_i,
  output trim_t shadow_o,
  output trim_t active_o
);

  trim_t shadow_q, active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= '0;
      active_q <= '0;
    end else begin
      if (we_i)   shadow_q <= wdata_i;
      if (load_i) active_q <= shadow_q;
    end
  end

  assign shadow_o = shadow_q;
  assign active_o = active_q;

  // R7: active setting changes only at a window boundary
  a_r7_active_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(active_q));
  a_r7_load_shadow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> active_q == $past(shadow_q));

endmodule

// File: rtl/rtc_trim_sched.sv
module rtc_trim_sched
  import rtc_trim_pkg::*;
#(
  parameter int unsigned WIN_P = 100000
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  osc_en_i,
  input  trim_t active_i,
  input  logic  near_wrap_i,
  output corr_e corr_o,
  output logic  win_end_o
);

  localparam int unsigned WIN_W = $clog2(WIN_P);
  localparam int unsigned SLOT  = WIN_P / MAX_STEPS;
  localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WIN_P - 1);

  logic [WIN_W-1:0]     win_q;
  logic [MAX_STEPS-1:0] hit;
  logic                 pend_q, pend_slow_q;
  logic                 due, req_v, req_slow, go;

  // evenly spaced correction slots, enabled by the step count
  for (genvar k = 0; k < MAX_STEPS; k++) begin : g_slot
    localparam logic [WIN_W-1:0] POS = WIN_W'(k * SLOT + SLOT / 2);
    assign hit[k] = (win_q == POS) && (int'(active_i.steps) > k);
  end

  assign due       = osc_en_i && (|hit);
  assign win_end_o = osc_en_i && (win_q == WIN_LAST);
  assign req_v     = pend_q || due;
  assign req_slow  = pend_q ? pend_slow_q : active_i.slow;
  assign go        = osc_en_i && req_v && !near_wrap_i;
  assign corr_o    = go ? (req_slow ? CORR_SKIP : CORR_ADD) : CORR_NONE;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q       <= '0;
      pend_q      <= 1'b0;
      pend_slow_q <= 1'b0;
    end else begin
      if (osc_en_i) win_q <= win_end_o ? '0 : win_q + 1'b1;
      pend_q      <= req_v && !go;
      pend_slow_q <= req_slow;
    end
  end

  // R3: a deferred correction never spills into the next window
  a_r3_no_spill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_end_o |-> !pend_q);
  // R8: window position frozen while idle
  a_r8_win_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !osc_en_i |=> $stable(win_q));

endmodule

// File: rtl/rtc_trim_divider.sv
module rtc_trim_divider
  import rtc_trim_pkg::*;
#(
  parameter int unsigned DIV_P = 32768
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  osc_en_i,
  input  corr_e corr_i,
  output logic  near_wrap_o,
  output logic  tick_o
);

  localparam int unsigned CNT_W = $clog2(DIV_P);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV_P - 1);
  localparam logic [CNT_W-1:0] NEAR = CNT_W'(DIV_P - 2);

  logic [CNT_W-1:0] cnt_q;
  logic             tick_q;

  assign near_wrap_o = (cnt_q >= NEAR);
  assign tick_o      = tick_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      tick_q <= osc_en_i && (cnt_q == LAST);
      if (osc_en_i) begin
        unique case (corr_i)
          CORR_ADD:  cnt_q <= cnt_q + CNT_W'(2);
          CORR_SKIP: cnt_q <= cnt_q;
          default:   cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        endcase
      end
    end
  end

  a_r4_add_two: assert property (@(posedge clk_i) disable iff (!rst_ni)
    osc_en_i && corr_i == CORR_ADD |=> cnt_q == $past(cnt_q) + CNT_W'(2));
  a_r4_skip_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    osc_en_i && corr_i == CORR_SKIP |=> $stable(cnt_q));
  a_r5_no_corr_at_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    corr_i != CORR_NONE |-> cnt_q < NEAR);
  a_r6_wrap_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    osc_en_i && cnt_q == LAST |=> tick_q && cnt_q == '0);
  a_r6_single_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_q |=> !tick_q);
  a_r8_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !osc_en_i |=> $stable(cnt_q) && !tick_q);

endmodule

// File: rtl/rtc_trim_prescaler.sv
module rtc_trim_prescaler
  import rtc_trim_pkg::*;
#(
  parameter int unsigned DIV_P = 32768,
  parameter int unsigned WIN_P = 100000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              osc_en_i,
  input  logic              trim_we_i,
  input  logic [TRIM_W-1:0] trim_wdata_i,
  output logic              sec_tick_o,
  output logic [TRIM_W-1:0] trim_o
);

  trim_t shadow, active;
  corr_e corr;
  logic  win_end, near_wrap;

  rtc_trim_reg u_reg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (trim_we_i),
    .wdata_i  (trim_t'(trim_wdata_i)),
    .load_i   (win_end),
    .shadow_o (shadow),
    .active_o (active)
  );

  rtc_trim_sched #(.WIN_P(WIN_P)) u_sched (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .osc_en_i    (osc_en_i),
    .active_i    (active),
    .near_wrap_i (near_wrap),
    .corr_o      (corr),
    .win_end_o   (win_end)
  );

  rtc_trim_divider #(.DIV_P(DIV_P)) u_div (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .osc_en_i    (osc_en_i),
    .corr_i      (corr),
    .near_wrap_o (near_wrap),
    .tick_o      (sec_tick_o)
  );

  assign trim_o = shadow;

  // R1: quiet output straight out of reset
  a_r1_reset_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !sec_tick_o);

endmodule

// File: tb/tb_rtc_trim_prescaler.sv
module tb_rtc_trim_prescaler;

  localparam int DIV = 16;
  localparam int WIN = 47;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       osc_en_i = 1'b0;
  logic       trim_we_i = 1'b0;
  logic [2:0] trim_wdata_i = 3'b000;
  logic       sec_tick_o;
  logic [2:0] trim_o;

  int checks = 0, errors = 0;
  int pos = 0, c_exp = 0, ticks = 0, dbl = 0, idle_ticks = 0;
  logic prev_tick = 1'b0;
  logic [2:0] act = 3'b000, pend = 3'b000;

  always #4 clk_i = ~clk_i;

  rtc_trim_prescaler #(.DIV_P(DIV), .WIN_P(WIN)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .osc_en_i(osc_en_i),
    .trim_we_i(trim_we_i), .trim_wdata_i(trim_wdata_i),
    .sec_tick_o(sec_tick_o), .trim_o(trim_o)
  );

  task automatic chk(input bit ok, input string req, input int act_v, input int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act_v, exp_v);
    end
  endtask

  // R2: bit 2 direction, bits 1:0 steps; 100 is zero
  function automatic int delta(input logic [2:0] c);
    return c[2] ? -int'(c[1:0]) : int'(c[1:0]);
  endfunction

  task automatic step(input logic en);
    osc_en_i = en;
    @(posedge clk_i);
    @(negedge clk_i);
    trim_we_i = 1'b0;
    if (sec_tick_o) begin
      ticks++;
      if (!en) idle_ticks++;
      if (prev_tick) dbl++;
    end
    prev_tick = sec_tick_o;
    if (en) begin
      pos++;
      if (pos == WIN) begin
        pos = 0;
        c_exp += WIN + delta(act);
        act = pend;
        // R3 R4 R5: cumulative ticks follow the per-window count
        chk(ticks == c_exp / DIV, "R3 R4 R5 window ticks", ticks, c_exp / DIV);
      end
    end
  endtask

  task automatic wr(input logic [2:0] code, input logic en);
    trim_we_i = 1'b1;
    trim_wdata_i = code;
    step(en);
    pend = code;
    chk(trim_o == code, "R7 readback", int'(trim_o), int'(code));
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [2:0] seq [8] = '{3'b000, 3'b011, 3'b111, 3'b001, 3'b100, 3'b010, 3'b101, 3'b110};
    repeat (3) @(negedge clk_i);
    chk(trim_o == 3'b000, "R1 reset trim", int'(trim_o), 0);
    chk(sec_tick_o == 1'b0, "R1 reset tick", int'(sec_tick_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int i = 0; i < 8; i++) begin
      int cyc = 0;
      logic gate = i[0];
      while (pos != 20) begin
        step(!(gate && (cyc % 5 == 4)));
        cyc++;
      end
      wr(seq[i], 1'b1);
      for (int w = 0; w < 5 * WIN; w++) begin
        step(!(gate && (cyc % 5 == 4)));
        cyc++;
      end
    end

    // R8: enable held low, nothing moves
    for (int j = 0; j < 40; j++) step(1'b0);
    chk(ticks == c_exp / DIV + 0 || pos != 0, "R8 idle hold", ticks, ticks);

    // R1: reset restores nominal rate from any state
    rst_ni = 1'b0;
    @(negedge clk_i);
    chk(trim_o == 3'b000, "R1 reset mid run", int'(trim_o), 0);
    chk(sec_tick_o == 1'b0, "R1 tick after reset", int'(sec_tick_o), 0);
    rst_ni = 1'b1;
    pos = 0; c_exp = 0; ticks = 0; act = 3'b000; pend = 3'b000; prev_tick = 1'b0;
    for (int j = 0; j < 3 * WIN; j++) step(1'b1);
    chk(ticks == (3 * WIN) / DIV, "R1 nominal after reset", ticks, (3 * WIN) / DIV);

    chk(dbl == 0, "R6 double tick", dbl, 0);
    chk(idle_ticks == 0, "R8 tick while idle", idle_ticks, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule